// File: doc/BRIEF.md
# CCM Decrypt Sequencing Controller

This block sequences a CCM decryption pass. It drives an external 128-bit block cipher through a request/response port. The cipher core sits outside the block. The block keeps a small context: the running counter, the recovered MAC and the computed tag. It accepts header and ciphertext blocks on a valid/ready input and writes the recovered plaintext to an output FIFO. When the pass ends it raises a done flag and a flag that says whether the MAC matched.

A pass begins with a one-cycle `start` pulse. At that pulse the block latches the IV, the initial counter, the encrypted MAC, and the header and data block counts. With `mode_init` set, the block first recovers the original MAC. It encrypts the initial counter and XORs the upper half of the result into the encrypted MAC. It then encrypts the IV, which seeds the CBC chain. The header blocks are absorbed into the chain next. Each ciphertext block is then handled in turn: the counter is stepped, the keystream block is produced, and the plaintext is recovered. That plaintext is sent out and also folded into the chain. With `mode_final` set, the upper 64 bits of the final chain value are compared with the recovered MAC.

Top module: `ccm_unwrap_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the block is idle. `done`, `mac_match`, `out_valid`, `in_ready` and `cph_req_valid` are all low, and `ctx_ctr`, `ctx_rmac` and `ctx_tag` are zero.
- R2: When `mode_init` is set, the first cipher request is the initial counter. The second is the IV. `ctx_rmac` becomes `emac_in` XOR bits [127:64] of E(counter).
- R3: At most one cipher request is in flight: `cph_req_valid` stays low from the request handshake until the response arrives. A pending request holds its data until `cph_req_ready` accepts it.
- R4: Header blocks are accepted on `in_valid && in_ready`. Each header block is XORed into the chain, and the result is re-encrypted. `in_ready` is never high while a cipher request is pending.
- R5: Before each data block, the low `CTR_INC_W` bits of the counter (the whole 128 bits by default) are incremented by one. The plaintext block equals E(counter) XOR the ciphertext block. Plaintext leaves on `out_data` in input order, exactly `dat_cnt` blocks.
- R6: Each plaintext block is XORed into the chain and then encrypted. After the last block, `ctx_tag` holds the final chain value.
- R7: `mac_match` is 1 only when `mode_final` was set and `ctx_tag[127:64]` equals `ctx_rmac`. It never rises without `done`.
- R8: When `mode_init` is clear, the block issues no counter or IV request. `iv_in` is used directly as the chain value, and `emac_in` is used directly as the recovered MAC.
- R9: While `out_full` is high, `out_valid` stays low and the pending plaintext and chain state are held. The output stream is unchanged by stalls.
- R10: `done` and `mac_match` hold their value until the next accepted `start`, and both are low the cycle after it.
- R11: A `start` pulse while a pass is running is ignored.
- R12: A counter whose low field is all ones wraps to zero on its next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a pass (accepted only when idle) |
| mode_init | input | 1 | Recover the MAC and encrypt the IV first |
| mode_final | input | 1 | Compare the tag with the recovered MAC at the end |
| hdr_cnt | input | CNT_W | Number of header blocks |
| dat_cnt | input | CNT_W | Number of ciphertext blocks |
| iv_in | input | BLK_W | IV (or carried chain value when `mode_init` is clear) |
| ctr_in | input | BLK_W | Initial counter value |
| emac_in | input | BLK_W/2 | Encrypted MAC (or recovered MAC when `mode_init` is clear) |
| in_valid | input | 1 | Input block valid |
| in_ready | output | 1 | Block can take an input block |
| in_data | input | BLK_W | Header or ciphertext block |
| out_valid | output | 1 | Push of a plaintext block into the FIFO |
| out_full | input | 1 | Output FIFO full |
| out_data | output | BLK_W | Plaintext block |
| cph_req_valid | output | 1 | Cipher request valid |
| cph_req_ready | input | 1 | Cipher accepts request |
| cph_req_data | output | BLK_W | Block to encrypt |
| cph_rsp_valid | input | 1 | Cipher result valid |
| cph_rsp_data | input | BLK_W | Encrypted block |
| ctx_ctr | output | BLK_W | Current counter |
| ctx_rmac | output | BLK_W/2 | Recovered MAC |
| ctx_tag | output | BLK_W | Computed MAC tag |
| done | output | 1 | Pass finished (sticky) |
| mac_match | output | 1 | Tag matched (sticky) |

## Verification
The bench targets a counter that wraps from all ones. A design that carried into the wrong bits, or stepped the counter after encrypting it, would produce a wrong keystream. The bench also runs frames with zero header and zero data blocks, where a routing error would hang the block or absorb a phantom block. It toggles the FIFO full signal and varies the cipher latency; a design that lost state under back-pressure would drop, duplicate or corrupt plaintext, or end with a wrong tag. Other runs send a start pulse mid-pass, clear the init and final modes, and give a MAC off by one bit. These catch a design that restarts mid-frame, issues step-one requests it should skip, or reports a match it has no right to.

// File: rtl/ccm_unwrap_pkg.sv
// Shared types for the CCM decrypt sequencer.
// Assumes: one sequencer state register; encodings are internal only.
package ccm_unwrap_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ENC_CTR0,
        ST_ENC_IV,
        ST_ROUTE,
        ST_HDR_IN,
        ST_HDR_ENC,
        ST_KS_ENC,
        ST_DAT_IN,
        ST_PUSH,
        ST_MAC_ENC,
        ST_FINISH
    } seq_state_e;

endpackage

// File: rtl/ccm_ctr_inc.sv
// Counter stepper: adds one to the low INC_W bits with wrap-around and
// passes the upper bits through unchanged.
// Assumes: 1 <= INC_W <= BLK_W.
module ccm_ctr_inc #(
    parameter int BLK_W = 128,
    parameter int INC_W = 128
) (
    input  logic [BLK_W-1:0] ctr_cur,
    output logic [BLK_W-1:0] ctr_nxt
);

    localparam logic [INC_W-1:0] STEP = {{(INC_W-1){1'b0}}, 1'b1};

    generate
        if (INC_W >= BLK_W) begin : g_full
            // whole word steps
            assign ctr_nxt = ctr_cur + {{(BLK_W-1){1'b0}}, 1'b1};
        end else begin : g_part
            // only the low field steps, upper bits are kept
            assign ctr_nxt = {ctr_cur[BLK_W-1:INC_W], ctr_cur[INC_W-1:0] + STEP};
        end
    endgenerate

endmodule

// File: rtl/ccm_tag_cmp.sv
// Tag comparator: compares the upper CMP_W bits of the chain value with the
// recovered MAC.
// Assumes: CMP_W <= BLK_W.
module ccm_tag_cmp #(
    parameter int BLK_W = 128,
    parameter int CMP_W = 64
) (
    input  logic [BLK_W-1:0] chain_v,
    input  logic [CMP_W-1:0] expect_v,
    output logic             equal_o
);

    assign equal_o = (chain_v[BLK_W-1 -: CMP_W] == expect_v);

endmodule

// File: rtl/ccm_cipher_port.sv
// Cipher request tracker: turns a level "issue" from the sequencer into a
// single valid/ready request and flags the matching response.
// Assumes: issue_data is held stable while issue is high; the cipher sends
// exactly one response per accepted request.
module ccm_cipher_port #(
    parameter int BLK_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [BLK_W-1:0] issue_data,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [BLK_W-1:0] req_data,
    input  logic             rsp_valid,
    output logic             rsp_take
);

    logic sent_q;

    assign req_valid = issue && !sent_q;
    assign req_data  = issue_data;
    assign rsp_take  = sent_q && rsp_valid;

    // Track whether the one allowed request is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)                     sent_q <= 1'b0;
        else if (rsp_take)              sent_q <= 1'b0;
        else if (req_valid && req_ready) sent_q <= 1'b1;
    end

    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_data)));

    a_r3_rsp_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> sent_q);

endmodule

// File: rtl/ccm_unwrap_ctrl.sv
// CCM decrypt sequencer. It recovers the MAC, runs the CBC chain over the
// header, and then does CTR decryption and CBC-MAC over the plaintext, one
// block at a time, through an external cipher.
// Assumes: hdr_cnt + dat_cnt blocks arrive on in_* after start; the cipher
// answers every accepted request once.
module ccm_unwrap_ctrl
    import ccm_unwrap_pkg::*;
#(
    parameter int BLK_W     = 128,
    parameter int CNT_W     = 8,
    parameter int CTR_INC_W = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 mode_init,
    input  logic                 mode_final,
    input  logic [CNT_W-1:0]     hdr_cnt,
    input  logic [CNT_W-1:0]     dat_cnt,
    input  logic [BLK_W-1:0]     iv_in,
    input  logic [BLK_W-1:0]     ctr_in,
    input  logic [BLK_W/2-1:0]   emac_in,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [BLK_W-1:0]     in_data,
    output logic                 out_valid,
    input  logic                 out_full,
    output logic [BLK_W-1:0]     out_data,
    output logic                 cph_req_valid,
    input  logic                 cph_req_ready,
    output logic [BLK_W-1:0]     cph_req_data,
    input  logic                 cph_rsp_valid,
    input  logic [BLK_W-1:0]     cph_rsp_data,
    output logic [BLK_W-1:0]     ctx_ctr,
    output logic [BLK_W/2-1:0]   ctx_rmac,
    output logic [BLK_W-1:0]     ctx_tag,
    output logic                 done,
    output logic                 mac_match
);

    localparam int TAG_W = BLK_W / 2;

    seq_state_e       state_q;
    logic [BLK_W-1:0] ctr_q, chain_q, ks_q, pt_q, tag_q, enc_data, ctr_step;
    logic [TAG_W-1:0] rmac_q;
    logic [CNT_W-1:0] hdr_left_q, dat_left_q;
    logic             init_q, final_q, done_q, match_q;
    logic             enc_want, rsp_take, tag_eq, in_take;

    // Which states need the cipher, and what they send.
    always_comb begin
        enc_want = 1'b0;
        enc_data = chain_q;
        case (state_q)
            ST_ENC_CTR0: begin enc_want = 1'b1; enc_data = ctr_q;   end
            ST_KS_ENC:   begin enc_want = 1'b1; enc_data = ctr_q;   end
            ST_ENC_IV,
            ST_HDR_ENC,
            ST_MAC_ENC:  begin enc_want = 1'b1; enc_data = chain_q; end
            default:     begin enc_want = 1'b0; enc_data = chain_q; end
        endcase
    end

    ccm_cipher_port #(.BLK_W(BLK_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (enc_want),
        .issue_data(enc_data),
        .req_valid (cph_req_valid),
        .req_ready (cph_req_ready),
        .req_data  (cph_req_data),
        .rsp_valid (cph_rsp_valid),
        .rsp_take  (rsp_take)
    );

    ccm_ctr_inc #(.BLK_W(BLK_W), .INC_W(CTR_INC_W)) u_inc (
        .ctr_cur(ctr_q),
        .ctr_nxt(ctr_step)
    );

    ccm_tag_cmp #(.BLK_W(BLK_W), .CMP_W(TAG_W)) u_cmp (
        .chain_v (chain_q),
        .expect_v(rmac_q),
        .equal_o (tag_eq)
    );

    assign in_ready  = (state_q == ST_HDR_IN) || (state_q == ST_DAT_IN);
    assign in_take   = in_ready && in_valid;
    assign out_valid = (state_q == ST_PUSH) && !out_full;
    assign out_data  = pt_q;
    assign ctx_ctr   = ctr_q;
    assign ctx_rmac  = rmac_q;
    assign ctx_tag   = tag_q;
    assign done      = done_q;
    assign mac_match = match_q;

    // Main sequencer: step order, context updates and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            ctr_q      <= '0;
            chain_q    <= '0;
            ks_q       <= '0;
            pt_q       <= '0;
            tag_q      <= '0;
            rmac_q     <= '0;
            hdr_left_q <= '0;
            dat_left_q <= '0;
            init_q     <= 1'b0;
            final_q    <= 1'b0;
            done_q     <= 1'b0;
            match_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ctr_q      <= ctr_in;
                        chain_q    <= iv_in;
                        rmac_q     <= emac_in;
                        hdr_left_q <= hdr_cnt;
                        dat_left_q <= dat_cnt;
                        init_q     <= mode_init;
                        final_q    <= mode_final;
                        done_q     <= 1'b0;
                        match_q    <= 1'b0;
                        state_q    <= mode_init ? ST_ENC_CTR0 : ST_ROUTE;
                    end
                end
                ST_ENC_CTR0: begin
                    if (rsp_take) begin
                        rmac_q  <= rmac_q ^ cph_rsp_data[BLK_W-1 -: TAG_W];
                        state_q <= ST_ENC_IV;
                    end
                end
                ST_ENC_IV: begin
                    if (rsp_take) begin
                        chain_q <= cph_rsp_data;
                        state_q <= ST_ROUTE;
                    end
                end
                ST_ROUTE: begin
                    if (hdr_left_q != '0) begin
                        state_q <= ST_HDR_IN;
                    end else if (dat_left_q != '0) begin
                        ctr_q   <= ctr_step;
                        state_q <= ST_KS_ENC;
                    end else begin
                        state_q <= ST_FINISH;
                    end
                end
                ST_HDR_IN: begin
                    if (in_take) begin
                        chain_q    <= chain_q ^ in_data;
                        hdr_left_q <= hdr_left_q - 1'b1;
                        state_q    <= ST_HDR_ENC;
                    end
                end
                ST_HDR_ENC: begin
                    if (rsp_take) begin
                        chain_q <= cph_rsp_data;
                        state_q <= ST_ROUTE;
                    end
                end
                ST_KS_ENC: begin
                    if (rsp_take) begin
                        ks_q    <= cph_rsp_data;
                        state_q <= ST_DAT_IN;
                    end
                end
                ST_DAT_IN: begin
                    if (in_take) begin
                        pt_q       <= ks_q ^ in_data;
                        dat_left_q <= dat_left_q - 1'b1;
                        state_q    <= ST_PUSH;
                    end
                end
                ST_PUSH: begin
                    if (!out_full) begin
                        chain_q <= chain_q ^ pt_q;
                        state_q <= ST_MAC_ENC;
                    end
                end
                ST_MAC_ENC: begin
                    if (rsp_take) begin
                        chain_q <= cph_rsp_data;
                        state_q <= ST_ROUTE;
                    end
                end
                ST_FINISH: begin
                    tag_q   <= chain_q;
                    match_q <= final_q && tag_eq;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    a_r4_in_excl: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !cph_req_valid);

    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PUSH && out_full) |=> (state_q == ST_PUSH && $stable(out_data)));

    a_r10_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(start && state_q == ST_IDLE)) |=> done);

    a_r7_match_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        mac_match |-> done);

    a_r8_no_step1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && !mode_init) |=> (state_q == ST_ROUTE));

endmodule

// File: tb/ccm_unwrap_ctrl_tb_top.sv
`timescale 1ns/1ps
module ccm_unwrap_ctrl_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0, mode_init = 1'b0, mode_final = 1'b0;
    logic [7:0]   hdr_cnt = '0, dat_cnt = '0;
    logic [127:0] iv_in = '0, ctr_in = '0, in_data = '0, out_data, cph_req_data, cph_rsp_data = '0;
    logic [63:0]  emac_in = '0, ctx_rmac;
    logic [127:0] ctx_ctr, ctx_tag;
    logic         in_valid = 1'b0, in_ready, out_valid, out_full = 1'b0;
    logic         cph_req_valid, cph_req_ready = 1'b0, cph_rsp_valid = 1'b0;
    logic         done, mac_match;

    int n_chk = 0, n_fail = 0;
    int lat = 1;
    int r3_viol = 0;
    bit stall_en = 0;
    int cyc = 0;
    logic [127:0] hdr_q[8], ct_q[8], exp_pt[8], got_q[8];
    int got_n = 0;

    always #2 clk = ~clk;

    ccm_unwrap_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_init(mode_init), .mode_final(mode_final),
        .hdr_cnt(hdr_cnt), .dat_cnt(dat_cnt), .iv_in(iv_in), .ctr_in(ctr_in), .emac_in(emac_in),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_full(out_full), .out_data(out_data),
        .cph_req_valid(cph_req_valid), .cph_req_ready(cph_req_ready), .cph_req_data(cph_req_data),
        .cph_rsp_valid(cph_rsp_valid), .cph_rsp_data(cph_rsp_data),
        .ctx_ctr(ctx_ctr), .ctx_rmac(ctx_rmac), .ctx_tag(ctx_tag), .done(done), .mac_match(mac_match)
    );

    // Stand-in block cipher: any fixed mixing function serves.
    function automatic logic [127:0] ciph(input logic [127:0] x);
        logic [127:0] y;
        y = {x[88:0], x[127:89]} ^ 128'h5A3C_96E1_0F87_D2B4_1E69_C3A5_7B2D_E84F;
        return y + {x[63:0], x[127:64]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Cipher model: accepts one request, answers after lat cycles.
    initial begin
        logic [127:0] cap;
        forever begin
            @(negedge clk);
            cph_rsp_valid = 1'b0;
            if (cph_req_valid && !cph_req_ready) begin
                repeat (lat - 1) @(negedge clk);
                cph_req_ready = 1'b1;
                cap = cph_req_data;
                @(negedge clk);
                cph_req_ready = 1'b0;
                repeat (lat) begin
                    if (cph_req_valid) r3_viol++;
                    @(negedge clk);
                end
                if (cph_req_valid) r3_viol++;
                cph_rsp_data  = ciph(cap);
                cph_rsp_valid = 1'b1;
            end
        end
    end

    // FIFO back-pressure, changed just after each rising edge.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 out_full = stall_en && ((cyc % 3) != 0);
    end

    // Output capture.
    always @(negedge clk) begin
        if (out_valid && got_n < 8) begin
            got_q[got_n] = out_data;
            got_n++;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic put_blk(input logic [127:0] d);
        bit rdy;
        in_valid = 1'b1;
        in_data  = d;
        forever begin
            rdy = in_ready;
            @(negedge clk);
            if (rdy) break;
        end
        in_valid = 1'b0;
    endtask

    // One frame: build data, compute expected results, run and compare.
    task automatic run_frame(input bit ini, input bit fin, input int nh, input int nd,
                             input int l, input bit stall, input bit poke, input bit bad,
                             input logic [127:0] ctr0, input string tag);
        logic [127:0] c, ch, e0, exp_tag;
        logic [63:0]  em, exp_rm;
        bit was_done;
        for (int i = 0; i < 8; i++) begin
            hdr_q[i] = {4{32'h1357_0000 + 32'(i * 97) + 32'(nh)}};
            ct_q[i]  = {4{32'hA0B0_0000 + 32'(i * 31) + 32'(nd)}} ^ ctr0;
        end
        iv_in = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0 ^ {96'd0, 32'(nh * 13 + nd)};
        c  = ctr0;
        ch = ini ? ciph(iv_in) : iv_in;
        for (int h = 0; h < nh; h++) ch = ciph(ch ^ hdr_q[h]);
        for (int d = 0; d < nd; d++) begin
            c = c + 128'd1;
            exp_pt[d] = ciph(c) ^ ct_q[d];
            ch = ciph(ch ^ exp_pt[d]);
        end
        exp_tag = ch;
        e0 = ciph(ctr0);
        exp_rm = exp_tag[127:64] ^ {63'd0, bad};
        em = ini ? (e0[127:64] ^ exp_rm) : exp_rm;

        lat = l; stall_en = stall; got_n = 0; r3_viol = 0;
        was_done = done;
        mode_init = ini; mode_final = fin; hdr_cnt = 8'(nh); dat_cnt = 8'(nd);
        ctr_in = ctr0; emac_in = em;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (was_done) chk(done == 1'b0, {"R10 done cleared ", tag}, 128'(done), 128'd0);
        fork
            begin
                for (int h = 0; h < nh; h++) put_blk(hdr_q[h]);
                for (int d = 0; d < nd; d++) put_blk(ct_q[d]);
            end
            begin
                if (poke) begin
                    repeat (6) @(negedge clk);
                    start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                end
            end
            begin
                while (!done) @(negedge clk);
            end
        join
        stall_en = 0;
        chk(got_n == nd, {"R5 block count ", tag}, 128'(got_n), 128'(nd));
        for (int d = 0; d < nd; d++)
            chk(got_q[d] == exp_pt[d], {"R5 plaintext ", tag}, got_q[d], exp_pt[d]);
        chk(ctx_tag == exp_tag, {"R6 R4 tag ", tag}, ctx_tag, exp_tag);
        chk(ctx_rmac == exp_rm, {"R2 R8 recovered mac ", tag}, 128'(ctx_rmac), 128'(exp_rm));
        chk(ctx_ctr == c, {"R5 R12 counter ", tag}, ctx_ctr, c);
        chk(mac_match == (fin && !bad), {"R7 match ", tag}, 128'(mac_match), 128'(fin && !bad));
        chk(r3_viol == 0, {"R3 outstanding ", tag}, 128'(r3_viol), 128'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!done && !mac_match, "R1 flags", 128'({done, mac_match}), 128'd0);
        chk(!out_valid && !in_ready && !cph_req_valid, "R1 handshakes",
            128'({out_valid, in_ready, cph_req_valid}), 128'd0);
        chk(ctx_ctr == '0 && ctx_tag == '0 && ctx_rmac == '0, "R1 context", ctx_ctr ^ ctx_tag, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_basic();
        run_frame(1, 1, 2, 3, 1, 0, 0, 0, 128'h0000_1111_2222_3333_4444_5555_6666_0001, "basic");
    endtask

    task automatic t_badmac();
        run_frame(1, 1, 1, 2, 2, 0, 0, 1, 128'h0123_4567_89AB_CDEF_0000_0000_0000_0010, "badmac");
    endtask

    task automatic t_stall();
        run_frame(1, 1, 3, 4, 3, 1, 0, 0, 128'h7777_0000_0000_0000_0000_0000_0000_00FF, "stall R9");
    endtask

    task automatic t_wrap();
        run_frame(1, 1, 0, 2, 1, 0, 0, 0, {128{1'b1}}, "wrap R12");
    endtask

    task automatic t_noinit();
        run_frame(0, 0, 1, 2, 1, 0, 0, 0, 128'h0000_0000_0000_0000_0000_0000_0000_0100, "noinit R8");
    endtask

    task automatic t_empty();
        run_frame(1, 1, 0, 0, 2, 0, 0, 0, 128'h55, "empty");
    endtask

    task automatic t_busy_start();
        run_frame(1, 1, 1, 2, 2, 0, 1, 0, 128'h99, "busy start R11");
    endtask

    task automatic t_done_hold();
        repeat (10) @(negedge clk);
        chk(done == 1'b1, "R10 done holds", 128'(done), 128'd1);
        chk(mac_match == 1'b1, "R10 match holds", 128'(mac_match), 128'd1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_badmac();
        t_stall();
        t_wrap();
        t_noinit();
        t_empty();
        t_busy_start();
        t_done_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule